// File: doc/BRIEF.md
# Linked Four-Channel Delay Pulse Generator

This block is the timing core of a delay and pulse generator. A trigger that is accepted while the core is idle and not inhibited starts a timing cycle. The reference output T0 rises a fixed number of clock cycles later. Four delay outputs, A through D, then rise one by one, each at its own effective cycle count after T0.

Each channel's delay is either measured from T0 or chained to another channel. When chained, the channel's effective time is the effective time of the channel it points to plus its own offset. Moving the referenced channel therefore moves every channel chained to it. All effective times are resolved and captured on the edge that accepts the trigger, so rewriting the inputs during a cycle affects only the next cycle.

Once an output rises it stays high. T0 and all four channels drop together a fixed hold time after the last channel rises, and the busy flag drops on the same edge. Two pair outputs follow the channels. The A/B pair output is high from the earlier to the later of A and B, and the C/D pair output does the same for C and D. Each pair output also has an inverted copy.

Top module: `linked_delay_gen`

## Requirements
- R1: A trigger sampled high on a clock edge while the core is idle and `inhibit_i` is low starts a cycle on that edge, and `t0_o` is high from LAT edges after that accepting edge.
- R2: A channel whose reference code is 0 (T0) rises LAT plus its offset edges after the accepting edge. Channel n takes its offset from `dly_i[n*DLY_W +: DLY_W]`, with n=0 for A through n=3 for D.
- R3: Channel n takes its reference code from `ref_i[n*3 +: 3]`. Codes 1, 2, 3 and 4 select A, B, C and D, and codes 0 and 5 to 7 select T0. A chained channel's effective time is the referenced channel's effective time plus its own offset.
- R4: T0 and every channel, once high, stay high. They all drop together HOLD edges after the edge on which the latest channel rose. Outside a cycle they are all low.
- R5: `ab_o` is high exactly while one of A and B is high and the other is not. `cd_o` behaves the same way for C and D.
- R6: `ab_n_o` and `cd_n_o` are always the inverse of `ab_o` and `cd_o`, which includes being high while idle.
- R7: `busy_o` rises on the accepting edge and falls on the edge where the outputs drop. A trigger seen while busy, including on the edge where busy falls, is dropped and not kept for later.
- R8: While `inhibit_i` is high, triggers are dropped, and releasing the inhibit does not start a cycle from an earlier trigger.
- R9: A channel that refers to itself, or that sits on a loop of references, is treated as referenced to T0. Channels chained onto such a channel add onto its fallback time.
- R10: Offsets and reference codes are captured on the accepting edge. Changes made during a cycle have no effect until the next cycle.
- R11: When A and B resolve to the same time, `ab_o` never rises in that cycle. The same holds for C and D with `cd_o`.
- R12: After reset, `busy_o`, `t0_o`, the channels and the pair outputs are low, and the inverted pair outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger request, sampled on each edge |
| inhibit_i | input | 1 | Blocks trigger acceptance while high |
| dly_i | input | 4*DLY_W | Per-channel offsets, channel A in the lowest field |
| ref_i | input | 12 | Per-channel 3-bit reference codes, channel A in the lowest field |
| t0_o | output | 1 | Reference output |
| ch_o | output | 4 | Delay outputs, bit 0 = A through bit 3 = D |
| ab_o | output | 1 | A/B pair output |
| ab_n_o | output | 1 | Inverted A/B pair output |
| cd_o | output | 1 | C/D pair output |
| cd_n_o | output | 1 | Inverted C/D pair output |
| busy_o | output | 1 | High for the duration of a timing cycle |

## Verification
The sensitive coincidence is a new trigger arriving on the same edge where the hold interval ends and busy falls. The bench raises the trigger in the last busy cycle of a run. It then expects busy to be low in each of the next two samples, which shows the trigger was neither accepted nor held over. A second coincidence is rewriting the offsets and references on the cycle right after acceptance. That run is still judged against the timing of the original settings, and a follow-up run is judged against the new ones. Alongside these, a sweep covers every reference combination, including self-references and loops, and checks every output in every cycle against times computed in the bench.

// File: rtl/ldg_pkg.sv
package ldg_pkg;

    // The pair outputs tie the design to exactly four channels.
    localparam int NCH   = 4;
    localparam int REF_W = 3;

    // Reference code 1..4 names channel 0..3; every other code means T0.
    function automatic logic ref_is_ch(input logic [REF_W-1:0] code);
        return (code >= 3'd1) && (code <= 3'd4);
    endfunction

    function automatic logic [1:0] ref_ch(input logic [REF_W-1:0] code);
        return 2'(code - 3'd1);
    endfunction

endpackage

// File: rtl/ldg_resolve.sv
module ldg_resolve
    import ldg_pkg::*;
#(
    parameter int DLY_W = 8,
    localparam int EFF_W = DLY_W + $clog2(NCH)
) (
    input  logic [NCH*DLY_W-1:0] dly_i,
    input  logic [NCH*REF_W-1:0] ref_i,
    output logic [NCH*EFF_W-1:0] eff_o,
    output logic [EFF_W-1:0]     eff_max_o
);

    always_comb begin
        logic [REF_W-1:0] code [NCH];
        logic [EFF_W-1:0] off  [NCH];
        logic [EFF_W-1:0] eff  [NCH];
        logic [NCH-1:0]   looped;
        logic [1:0]       cur;
        logic             live;

        for (int c = 0; c < NCH; c++) begin
            code[c] = ref_i[c*REF_W +: REF_W];
            off[c]  = EFF_W'(dly_i[c*DLY_W +: DLY_W]);
        end

        // A channel lies on a loop when its chain comes back to itself.
        for (int c = 0; c < NCH; c++) begin
            looped[c] = 1'b0;
            cur       = 2'(c);
            live      = 1'b1;
            for (int s = 0; s < NCH; s++) begin
                if (live) begin
                    if (ref_is_ch(code[cur])) begin
                        cur = ref_ch(code[cur]);
                        if (cur == 2'(c)) begin
                            looped[c] = 1'b1;
                            live      = 1'b0;
                        end
                    end else begin
                        live = 1'b0;
                    end
                end
            end
        end

        // With loop members cut to T0 the graph is acyclic, depth < NCH.
        for (int c = 0; c < NCH; c++) begin
            eff[c] = off[c];
        end
        for (int p = 0; p < NCH - 1; p++) begin
            for (int c = 0; c < NCH; c++) begin
                if (ref_is_ch(code[c]) && !looped[c]) begin
                    eff[c] = off[c] + eff[ref_ch(code[c])];
                end
            end
        end

        eff_max_o = '0;
        for (int c = 0; c < NCH; c++) begin
            eff_o[c*EFF_W +: EFF_W] = eff[c];
            if (eff[c] > eff_max_o) begin
                eff_max_o = eff[c];
            end
        end
    end

endmodule

// File: rtl/ldg_seq.sv
module ldg_seq
    import ldg_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int LAT   = 2,
    parameter int HOLD  = 4,
    localparam int EFF_W = DLY_W + $clog2(NCH),
    localparam int CNT_W = $clog2(NCH * (2 ** DLY_W) + LAT + HOLD) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_i,
    input  logic                 inhibit_i,
    input  logic [NCH*EFF_W-1:0] eff_i,
    input  logic [EFF_W-1:0]     eff_max_i,
    output logic                 busy_o,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [NCH*EFF_W-1:0] eff_o
);

    typedef struct packed {
        logic                 busy;
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     last;
        logic [NCH*EFF_W-1:0] eff;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (trig_i && !inhibit_i) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.eff  = eff_i;
                st_d.last = CNT_W'(LAT) + CNT_W'(eff_max_i) + CNT_W'(HOLD) - CNT_W'(1);
            end
        end else if (st_q.cnt == st_q.last) begin
            st_d.busy = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign cnt_o  = st_q.cnt;
    assign eff_o  = st_q.eff;

    // A running cycle keeps counting whatever the trigger does.
    assert_busy_ignores_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != st_q.last) |=> (st_q.busy && st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

    // A cycle only starts from an uninhibited trigger.
    assert_inhibit_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> ($past(trig_i) && !$past(inhibit_i)));

    // Captured delays do not move during a cycle.
    assert_latched_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> $stable(st_q.eff));

endmodule

// File: rtl/ldg_outs.sv
module ldg_outs
    import ldg_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int LAT   = 2,
    parameter int HOLD  = 4,
    localparam int EFF_W = DLY_W + $clog2(NCH),
    localparam int CNT_W = $clog2(NCH * (2 ** DLY_W) + LAT + HOLD) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy_i,
    input  logic [CNT_W-1:0]     cnt_i,
    input  logic [NCH*EFF_W-1:0] eff_i,
    output logic                 t0_o,
    output logic [NCH-1:0]       ch_o,
    output logic                 ab_o,
    output logic                 ab_n_o,
    output logic                 cd_o,
    output logic                 cd_n_o
);

    assign t0_o = busy_i && (cnt_i >= CNT_W'(LAT));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_o[g] = busy_i &&
            (cnt_i >= CNT_W'(LAT) + CNT_W'(eff_i[g*EFF_W +: EFF_W]));

        // Once high, a channel stays high until the cycle ends.
        assert_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_o[g] && busy_i) |=> (ch_o[g] || !busy_i));
    end

    // A pair is high in the window where one channel has fired and the other has not.
    always_comb begin
        ab_o   = ch_o[0] != ch_o[1];
        cd_o   = ch_o[2] != ch_o[3];
        ab_n_o = !ab_o;
        cd_n_o = !cd_o;
    end

    assert_pulse_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ab_o |-> (t0_o && (ch_o[0] || ch_o[1])));

    assert_no_zero_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && eff_i[0 +: EFF_W] == eff_i[EFF_W +: EFF_W]) |-> !ab_o);

endmodule

// File: rtl/linked_delay_gen.sv
module linked_delay_gen
    import ldg_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int LAT   = 2,
    parameter int HOLD  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_i,
    input  logic                 inhibit_i,
    input  logic [4*DLY_W-1:0]   dly_i,
    input  logic [11:0]          ref_i,
    output logic                 t0_o,
    output logic [3:0]           ch_o,
    output logic                 ab_o,
    output logic                 ab_n_o,
    output logic                 cd_o,
    output logic                 cd_n_o,
    output logic                 busy_o
);

    localparam int EFF_W = DLY_W + $clog2(NCH);
    localparam int CNT_W = $clog2(NCH * (2 ** DLY_W) + LAT + HOLD) + 1;

    logic [NCH*EFF_W-1:0] eff_now;
    logic [EFF_W-1:0]     eff_max;
    logic [NCH*EFF_W-1:0] eff_cap;
    logic [CNT_W-1:0]     cnt;
    logic                 busy;

    ldg_resolve #(.DLY_W(DLY_W)) u_resolve (
        .dly_i     (dly_i),
        .ref_i     (ref_i),
        .eff_o     (eff_now),
        .eff_max_o (eff_max)
    );

    ldg_seq #(.DLY_W(DLY_W), .LAT(LAT), .HOLD(HOLD)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .inhibit_i (inhibit_i),
        .eff_i     (eff_now),
        .eff_max_i (eff_max),
        .busy_o    (busy),
        .cnt_o     (cnt),
        .eff_o     (eff_cap)
    );

    ldg_outs #(.DLY_W(DLY_W), .LAT(LAT), .HOLD(HOLD)) u_outs (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy),
        .cnt_i  (cnt),
        .eff_i  (eff_cap),
        .t0_o   (t0_o),
        .ch_o   (ch_o),
        .ab_o   (ab_o),
        .ab_n_o (ab_n_o),
        .cd_o   (cd_o),
        .cd_n_o (cd_n_o)
    );

    assign busy_o = busy;

    // Nothing is driven outside a cycle.
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!t0_o && ch_o == 4'b0000 && !ab_o && !cd_o));

endmodule

// File: tb/linked_delay_gen_tb.sv
module linked_delay_gen_tb_top;

    localparam int DLY_W = 8;
    localparam int LAT   = 2;
    localparam int HOLD  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_i = 1'b0;
    logic             inhibit_i = 1'b0;
    logic [4*DLY_W-1:0] dly_i = '0;
    logic [11:0]      ref_i = '0;
    logic             t0_o, ab_o, ab_n_o, cd_o, cd_n_o, busy_o;
    logic [3:0]       ch_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    linked_delay_gen #(.DLY_W(DLY_W), .LAT(LAT), .HOLD(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .inhibit_i(inhibit_i),
        .dly_i(dly_i), .ref_i(ref_i), .t0_o(t0_o), .ch_o(ch_o),
        .ab_o(ab_o), .ab_n_o(ab_n_o), .cd_o(cd_o), .cd_n_o(cd_n_o),
        .busy_o(busy_o)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Bench model of reference resolution.
    function automatic int tgt(input int code);
        return (code >= 1 && code <= 4) ? code - 1 : -1;
    endfunction

    function automatic bit on_loop(input int refs[4], input int c);
        int cur = c;
        for (int s = 0; s < 4; s++) begin
            if (tgt(refs[cur]) < 0) return 1'b0;
            cur = tgt(refs[cur]);
            if (cur == c) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic int eff_of(input int offs[4], input int refs[4], input int c);
        int cur = c;
        int sum = 0;
        for (int s = 0; s < 4; s++) begin
            sum += offs[cur];
            if (on_loop(refs, cur) || tgt(refs[cur]) < 0) return sum;
            cur = tgt(refs[cur]);
        end
        return sum;
    endfunction

    task automatic apply(input int offs[4], input int refs[4]);
        for (int c = 0; c < 4; c++) begin
            dly_i[c*DLY_W +: DLY_W] = DLY_W'(offs[c]);
            ref_i[c*3 +: 3]         = 3'(refs[c]);
        end
    endtask

    // mode 0 plain, 1 rewrite inputs mid-cycle (R10), 2 trigger while busy (R7),
    // 3 trigger on the final busy edge (R7)
    task automatic run(input int offs[4], input int refs[4], input int mode,
                       input int offs2[4], input int refs2[4]);
        int eff[4];
        int mx = 0;
        int total;
        string ctag[4];
        for (int c = 0; c < 4; c++) begin
            eff[c] = eff_of(offs, refs, c);
            if (eff[c] > mx) mx = eff[c];
            ctag[c] = on_loop(refs, c) ? "R9" : (tgt(refs[c]) >= 0 ? "R3" : "R2");
        end
        total = LAT + mx + HOLD;
        apply(offs, refs);
        @(negedge clk);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        for (int k = 0; k <= total + 1; k++) begin
            logic e_ch[4];
            logic e_ab, e_cd;
            for (int c = 0; c < 4; c++) e_ch[c] = (k >= LAT + eff[c]) && (k < total);
            e_ab = e_ch[0] ^ e_ch[1];
            e_cd = e_ch[2] ^ e_ch[3];
            chk("R7", "busy", busy_o, k < total);
            chk("R1", "t0", t0_o, (k >= LAT) && (k < total));
            for (int c = 0; c < 4; c++) chk(ctag[c], $sformatf("ch%0d", c), ch_o[c], e_ch[c]);
            chk("R5", "ab", ab_o, e_ab);
            chk("R5", "cd", cd_o, e_cd);
            chk("R6", "ab_n", ab_n_o, !e_ab);
            chk("R6", "cd_n", cd_n_o, !e_cd);
            if (mode == 1 && k == 0) apply(offs2, refs2);
            if (mode == 2) trig_i = (k == 2 || k == 3);
            if (mode == 3) trig_i = (k == total - 1);
            @(negedge clk);
        end
        trig_i = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R7 watchdog: actual hung expected finish");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int o[4], r[4], o2[4], r2[4];
        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12", "busy", busy_o, 1'b0);
        chk("R12", "t0", t0_o, 1'b0);
        chk("R12", "ch", |ch_o, 1'b0);
        chk("R12", "ab_n", ab_n_o, 1'b1);
        chk("R12", "cd_n", cd_n_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "busy after release", busy_o, 1'b0);

        // R8: inhibited triggers dropped and not held
        inhibit_i = 1'b1;
        trig_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8", "busy inhibited", busy_o, 1'b0);
        end
        trig_i = 1'b0;
        inhibit_i = 1'b0;
        @(negedge clk);
        chk("R8", "busy after release", busy_o, 1'b0);
        @(negedge clk);
        chk("R8", "busy later", ch_o[0] | busy_o, 1'b0);

        // Sweep every combination of codes 0..4 with small varied offsets
        // (R2, R3, R4, R5, R9, R11)
        for (int idx = 0; idx < 625; idx++) begin
            int v = idx;
            for (int c = 0; c < 4; c++) begin
                r[c] = v % 5;
                v = v / 5;
                o[c] = (idx * 3 + c * 5 + idx / 7) % 4;
            end
            run(o, r, 0, o, r);
        end

        // R3: codes 5..7 mean T0
        o = '{3, 1, 2, 0}; r = '{5, 6, 7, 0};
        run(o, r, 0, o, r);
        // R3: full-width chain D<-C<-B<-A
        o = '{255, 255, 255, 255}; r = '{0, 1, 2, 3};
        run(o, r, 0, o, r);
        // R11: equal resolved times for both pairs
        o = '{5, 0, 7, 0}; r = '{0, 1, 0, 3};
        run(o, r, 0, o, r);
        // R10: rewrite right after capture, then a run with new settings
        o = '{2, 6, 1, 3}; r = '{0, 0, 1, 0};
        o2 = '{9, 1, 4, 4}; r2 = '{2, 0, 0, 3};
        run(o, r, 1, o2, r2);
        run(o2, r2, 0, o2, r2);
        // R7: trigger during a cycle and on the final busy edge
        o = '{3, 4, 1, 7}; r = '{0, 1, 0, 0};
        run(o, r, 2, o, r);
        run(o, r, 3, o, r);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule